// File: doc/BRIEF.md
# Burst Page-Mode Parallel Memory Controller

This block sits on the host side of a byte-wide parallel nonvolatile RAM that has eight-byte rows. It takes one burst request at a time, made of a start address, a length and a direction. It turns that request into chip-enable, write-enable, output-enable and address sequences on the memory pins. Within a row it keeps chip enable low and steps only the three column bits, so each further byte costs one short page access. When the burst moves to a new row, and again when the burst ends, it raises chip enable for a precharge period.

Write bytes enter through a valid/ready stream. The controller raises `wr_ready` only while it is waiting for the next byte, so a host that holds `wr_valid` low simply stretches the burst, with chip enable held low and write enable high. Read bytes leave as a one-cycle `rd_valid` pulse with `rd_data`, in ascending address order. There is no back-pressure on reads, so the consumer must take every pulse. The bidirectional data pins appear as separate out, in and enable signals. Every timing interval is a cycle-count parameter.

Top module: `pmem_burst_ctrl`

## Requirements
- R1: While reset is asserted and whenever the controller is idle, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are high, and `mem_dq_oe`, `busy`, `wr_ready` and `rd_valid` are low.
- R2: A request is taken on a clock edge where `req_valid` is high and `busy` is low. `busy` rises in the next cycle and stays high until the final precharge ends. A `req_valid` seen while `busy` is high is ignored.
- R3: Each row segment begins with one setup cycle in which the address is driven with chip enable high. Chip enable then falls. For reads, the first byte of the segment is sampled after `T_INIT` cycles with chip enable low.
- R4: While chip enable stays low, the row bits (address above bit 2) do not change. Each further byte of a read in the same row is sampled `T_PAGE` cycles after the column step.
- R5: Each read byte appears as a single-cycle `rd_valid` pulse one cycle after it is sampled. Bytes come in ascending address order, and exactly one pulse is produced per requested byte.
- R6: For writes, each byte is written by one low pulse of `mem_we_n` lasting `T_WE` cycles. The byte is driven from the start of the pulse until one cycle after the pulse rises, with the address held steady. `mem_oe_n` stays high for the whole write burst, and `wr_ready` is high only while chip enable is low and write enable is high.
- R7: When a burst crosses a row boundary (the column moves from 7 to 0), chip enable rises for `T_PRE` cycles before a fresh setup and initial access at the next row. Before any falling edge, chip enable has been high for at least `T_PRE` cycles.
- R8: After the last byte, chip enable stays high for `T_PRE` cycles, and then `busy` falls.
- R9: `req_len_m1` encodes the length minus one, so lengths of 1 to 256 bytes are accepted. The address wraps from its maximum value to zero.
- R10: `mem_dq_oe` is high only during a write pulse and the cycle after it, never while chip enable is high or output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Burst request strobe |
| req_addr | input | ADDR_W | First byte address |
| req_len_m1 | input | LEN_W | Burst length minus one |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| busy | output | 1 | Burst in progress, including the final precharge |
| wr_valid | input | 1 | Write byte offered |
| wr_data | input | DATA_W | Write byte |
| wr_ready | output | 1 | Controller takes the write byte on this edge if `wr_valid` is high |
| rd_valid | output | 1 | One-cycle read byte strobe |
| rd_data | output | DATA_W | Read byte |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | DATA_W | Data pin output value |
| mem_dq_oe | output | 1 | Data pin output enable |
| mem_dq_in | input | DATA_W | Data pin input value |

## Verification
Count from the cycle after a request is accepted, with the setup cycle as cycle 1. In a read segment starting at cycle t, the first byte's `rd_valid` is due at cycle t+`T_INIT`+1, and each later byte in the row comes `T_PAGE` cycles after the one before it. With writes offered back to back, each byte takes `T_WE`+2 cycles. A row change inserts `T_PRE` precharge cycles and then a new setup cycle, and `busy` drops `T_PRE` cycles after the last byte ends. The bench computes these cycle numbers from the request alone. It records the cycle number of every `rd_valid` and the last cycle in which `busy` is high, samples on falling clock edges, and compares both the positions and the data with its own expected values.

// File: rtl/pmem_pkg.sv
package pmem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_RACC,
    ST_WWAIT,
    ST_WLOW,
    ST_WHI,
    ST_PRE
  } pm_state_e;
endpackage

// File: rtl/pmem_cycle_timer.sv
module pmem_cycle_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [CW-1:0] lim,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  assign done = (cnt_q == lim - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr)   cnt_q <= '0;
    else if (!done) cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/pmem_burst_track.sv
module pmem_burst_track #(
  parameter int ADDR_W = 15,
  parameter int LEN_W  = 8,
  parameter int COL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [LEN_W-1:0]  ld_len_m1,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              last,
  output logic              row_end
);
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;

  assign addr    = addr_q;
  assign last    = (rem_q == '0);
  assign row_end = &addr_q[COL_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rem_q  <= '0;
    end else if (load) begin
      addr_q <= ld_addr;
      rem_q  <= ld_len_m1;
    end else if (step) begin
      addr_q <= addr_q + ADDR_W'(1);
      rem_q  <= rem_q - LEN_W'(1);
    end
  end
endmodule

// File: rtl/pmem_burst_ctrl.sv
module pmem_burst_ctrl
  import pmem_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 8,
  parameter int COL_W  = 3,
  parameter int T_INIT = 4,
  parameter int T_PAGE = 2,
  parameter int T_WE   = 2,
  parameter int T_PRE  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len_m1,
  input  logic              req_write,
  output logic              busy,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int T_MAX = (T_INIT > T_PAGE ? T_INIT : T_PAGE) > (T_WE > T_PRE ? T_WE : T_PRE)
                       ? (T_INIT > T_PAGE ? T_INIT : T_PAGE) : (T_WE > T_PRE ? T_WE : T_PRE);
  localparam int CW = $clog2(T_MAX + 1);
  localparam logic [CW-1:0] L_INIT = CW'(T_INIT);
  localparam logic [CW-1:0] L_PAGE = CW'(T_PAGE);
  localparam logic [CW-1:0] L_WE   = CW'(T_WE);
  localparam logic [CW-1:0] L_PRE  = CW'(T_PRE);

  pm_state_e st_q, st_d;
  logic dir_q, fin_q, first_q, rvld_q;
  logic [DATA_W-1:0] wdat_q, rdat_q;
  logic trk_load, trk_step, trk_last, trk_row_end;
  logic byte_done, page_step;
  logic tmr_clr, tmr_done;
  logic [CW-1:0] tmr_lim;

  pmem_burst_track #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .COL_W(COL_W)) u_track (
    .clk(clk), .rst_n(rst_n), .load(trk_load), .ld_addr(req_addr),
    .ld_len_m1(req_len_m1), .step(trk_step), .addr(mem_addr),
    .last(trk_last), .row_end(trk_row_end)
  );

  pmem_cycle_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .lim(tmr_lim), .done(tmr_done)
  );

  always_comb begin
    case (st_q)
      ST_RACC: tmr_lim = first_q ? L_INIT : L_PAGE;
      ST_WLOW: tmr_lim = L_WE;
      ST_PRE:  tmr_lim = L_PRE;
      default: tmr_lim = CW'(1);
    endcase
  end

  always_comb begin
    st_d      = st_q;
    trk_load  = 1'b0;
    trk_step  = 1'b0;
    byte_done = 1'b0;
    page_step = 1'b0;
    case (st_q)
      ST_IDLE:  if (req_valid) begin trk_load = 1'b1; st_d = ST_SETUP; end
      ST_SETUP: st_d = dir_q ? ST_WWAIT : ST_RACC;
      ST_RACC:  byte_done = tmr_done;
      ST_WWAIT: if (wr_valid) st_d = ST_WLOW;
      ST_WLOW:  if (tmr_done) st_d = ST_WHI;
      ST_WHI:   byte_done = 1'b1;
      ST_PRE:   if (tmr_done) st_d = fin_q ? ST_IDLE : ST_SETUP;
      default:  st_d = ST_IDLE;
    endcase
    if (byte_done) begin
      if (trk_last) begin
        st_d = ST_PRE;
      end else begin
        trk_step = 1'b1;
        if (trk_row_end) begin
          st_d = ST_PRE;
        end else begin
          page_step = 1'b1;
          st_d = (st_q == ST_RACC) ? ST_RACC : ST_WWAIT;
        end
      end
    end
  end

  assign tmr_clr = (st_d != st_q) | page_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      dir_q   <= 1'b0;
      fin_q   <= 1'b0;
      first_q <= 1'b0;
      rvld_q  <= 1'b0;
      rdat_q  <= '0;
      wdat_q  <= '0;
    end else begin
      st_q   <= st_d;
      rvld_q <= (st_q == ST_RACC) && tmr_done;
      if (trk_load) begin
        dir_q <= req_write;
        fin_q <= 1'b0;
      end else if (byte_done && trk_last) begin
        fin_q <= 1'b1;
      end
      if (st_q == ST_SETUP) first_q <= 1'b1;
      else if (page_step)   first_q <= 1'b0;
      if ((st_q == ST_RACC) && tmr_done) rdat_q <= mem_dq_in;
      if ((st_q == ST_WWAIT) && wr_valid) wdat_q <= wr_data;
    end
  end

  assign busy       = (st_q != ST_IDLE);
  assign wr_ready   = (st_q == ST_WWAIT);
  assign rd_valid   = rvld_q;
  assign rd_data    = rdat_q;
  assign mem_ce_n   = (st_q == ST_IDLE) || (st_q == ST_SETUP) || (st_q == ST_PRE);
  assign mem_oe_n   = (st_q != ST_RACC);
  assign mem_we_n   = (st_q != ST_WLOW);
  assign mem_dq_oe  = (st_q == ST_WLOW) || (st_q == ST_WHI);
  assign mem_dq_out = wdat_q;
endmodule

// File: rtl/pmem_burst_chk.sv
module pmem_burst_chk #(
  parameter int ADDR_W = 15,
  parameter int COL_W  = 3,
  parameter int T_WE   = 2,
  parameter int T_PRE  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe
);
  logic [15:0] hi_cnt, lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= 16'(T_PRE);
      lo_cnt <= '0;
    end else begin
      hi_cnt <= mem_ce_n ? ((hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 16'd1) : 16'd0;
      lo_cnt <= mem_we_n ? 16'd0 : ((lo_cnt == 16'hFFFF) ? lo_cnt : lo_cnt + 16'd1);
    end
  end

  a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));
  a_r4_row_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr[ADDR_W-1:COL_W]));
  a_r6_oe_off_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && mem_dq_oe && !mem_ce_n));
  a_r6_we_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (lo_cnt == 16'(T_WE)));
  a_r6_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |=> $stable(mem_addr));
  a_r6_ready_phase: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (!mem_ce_n && mem_we_n && mem_oe_n));
  a_r7_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> (hi_cnt >= 16'(T_PRE)));
  a_r10_dq_window: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_ce_n && mem_oe_n));
endmodule

bind pmem_burst_ctrl pmem_burst_chk #(
  .ADDR_W(ADDR_W), .COL_W(COL_W), .T_WE(T_WE), .T_PRE(T_PRE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .wr_ready(wr_ready), .mem_addr(mem_addr),
  .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/pmem_burst_ctrl_bench.sv
module pmem_burst_ctrl_bench;
  localparam int AW = 10, LW = 8, DW = 8;
  localparam int TI = 4, TP = 2, TW = 2, TR = 3;
  localparam int MSZ = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, wr_valid = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len_m1 = '0;
  logic [DW-1:0] wr_data;
  logic busy, wr_ready, rd_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [DW-1:0] rd_data, mem_dq_out, mem_dq_in;
  logic [AW-1:0] mem_addr;

  always #2 clk = ~clk;

  pmem_burst_ctrl #(.ADDR_W(AW), .LEN_W(LW), .DATA_W(DW), .COL_W(3),
    .T_INIT(TI), .T_PAGE(TP), .T_WE(TW), .T_PRE(TR)) u_pmem_burst_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_len_m1(req_len_m1), .req_write(req_write), .busy(busy),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  logic [DW-1:0] pinmem [MSZ];
  logic [DW-1:0] refmem [MSZ];
  logic [DW-1:0] wq [256];
  int widx = 0;
  int checks = 0, errors = 0;
  int ncyc = 0, base = 0, last_busy = 0, rd_n = 0;
  int rd_i [256];
  logic [DW-1:0] rd_d [256];
  bit gap_mode = 1'b0;
  int ce_hi = 0, we_lo = 0;
  logic [AW-1:0] prev_addr;
  logic prev_ce_n = 1'b1;

  assign wr_data   = wq[widx];
  assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ? pinmem[mem_addr] : 8'h00;

  always @(posedge mem_we_n)
    if (rst_n === 1'b1 && mem_ce_n === 1'b0 && mem_dq_oe === 1'b1)
      pinmem[mem_addr] = mem_dq_out;

  always @(posedge clk) if (wr_valid && wr_ready) widx <= widx + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // pin monitor, sampled on the falling edge
  always @(negedge clk) begin
    ncyc = ncyc + 1;
    wr_valid = gap_mode ? ($urandom % 3 != 0) : 1'b1;
    if (rst_n) begin
      if (busy) last_busy = ncyc - base;
      if (rd_valid && rd_n < 256) begin
        rd_i[rd_n] = ncyc - base;
        rd_d[rd_n] = rd_data;
        rd_n++;
      end
      if (mem_dq_oe && (mem_ce_n || !mem_oe_n))
        check(0, "R10 data driven outside write", 1, 0);
      if (!mem_we_n && !mem_oe_n) check(0, "R6 oe low during we", 0, 1);
      if (!mem_ce_n && !prev_ce_n && (mem_addr[AW-1:3] != prev_addr[AW-1:3]))
        check(0, "R4 row changed with ce low", int'(mem_addr), int'(prev_addr));
      if (!mem_ce_n && prev_ce_n && ce_hi < TR)
        check(0, "R7 short precharge", ce_hi, TR);
      if (mem_we_n && we_lo != 0 && we_lo != TW) check(0, "R6 we pulse width", we_lo, TW);
      ce_hi = mem_ce_n ? ce_hi + 1 : 0;
      we_lo = mem_we_n ? 0 : we_lo + 1;
      prev_ce_n = mem_ce_n;
      prev_addr = mem_addr;
    end
  end

  task automatic burst(input int addr, input int len, input bit wr, input bit gap, input bit hold);
    int t, e, nb, a, errs0;
    int exp_i [256];
    bit crossed;
    errs0 = errors;
    gap_mode = gap;
    if (wr) for (int i = 0; i < len; i++) wq[i] = 8'($urandom);
    @(negedge clk);
    widx = 0;
    rd_n = 0;
    req_valid = 1'b1; req_addr = AW'(addr); req_len_m1 = LW'(len - 1); req_write = wr;
    @(posedge clk);
    base = ncyc;
    @(negedge clk);
    if (!hold) req_valid = 1'b0;
    req_addr = AW'(addr + 5);
    req_write = ~wr;
    for (int k = 0; k < 4 && hold; k++) @(negedge clk);
    req_valid = 1'b0;
    do @(negedge clk); while (busy);
    // expected schedule
    t = 1; e = 0; crossed = 0;
    for (int i = 0; i < len; i++) begin
      a = (addr + i) % MSZ;
      if (i > 0 && (a % 8) == 0) begin t = e + TR + 1; crossed = 1; end
      if (wr) e = (i == 0 || (a % 8) == 0) ? t + 2 + TW : e + 2 + TW;
      else    e = (i == 0 || (a % 8) == 0) ? t + TI : e + TP;
      exp_i[i] = e + 1;
    end
    if (!gap) check(last_busy == e + TR, "R8 busy end cycle", last_busy, e + TR);
    if (wr) begin
      check(rd_n == 0, "R5 no read pulses in write", rd_n, 0);
      for (int i = 0; i < len; i++) begin
        a = (addr + i) % MSZ;
        refmem[a] = wq[i];
        check(pinmem[a] == refmem[a], crossed ? "R7 write data across row" : "R6 write data",
              int'(pinmem[a]), int'(refmem[a]));
      end
    end else begin
      check(rd_n == len, "R5 read pulse count", rd_n, len);
      for (int i = 0; i < len && i < rd_n; i++) begin
        a = (addr + i) % MSZ;
        check(rd_d[i] == refmem[a], "R5 read data order", int'(rd_d[i]), int'(refmem[a]));
        check(rd_i[i] == exp_i[i], i == 0 ? "R3 first byte cycle" :
              ((a % 8) == 0 ? "R7 row restart cycle" : "R4 page byte cycle"), rd_i[i], exp_i[i]);
      end
    end
    check(errors == errs0, "R9 burst completed cleanly", errors - errs0, 0);
    gap_mode = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "R2 watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < MSZ; i++) begin
      pinmem[i] = 8'((i * 37 + 5) ^ (i >> 3));
      refmem[i] = pinmem[i];
    end
    repeat (3) @(negedge clk);
    check(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !busy && !rd_valid && !wr_ready,
          "R1 pins during reset", 0, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_ce_n && mem_we_n && mem_oe_n && !busy, "R1 idle after reset", int'(busy), 0);
    burst(16, 1, 0, 0, 0);         // single byte, R9 minimum
    burst(64, 8, 0, 0, 0);         // full row: 1 initial + 7 page + precharge
    burst(5, 6, 0, 0, 0);          // crosses a row, R7
    burst(100, 8, 1, 0, 0);        // write crossing rows
    burst(100, 8, 0, 0, 0);
    burst(200, 256, 1, 0, 0);      // maximum length, R9
    burst(200, 256, 0, 0, 0);
    burst(MSZ - 4, 8, 1, 0, 0);    // address wrap, R9
    burst(MSZ - 4, 8, 0, 0, 0);
    burst(300, 20, 0, 0, 1);       // request held while busy, R2
    repeat (3) begin
      @(negedge clk);
      check(!busy && mem_ce_n && rd_n == 20, "R2 request during busy ignored", int'(busy), 0);
    end
    burst(400, 13, 1, 1, 0);       // write back-pressure
    burst(400, 13, 0, 0, 0);
    for (int n = 0; n < 30; n++) begin
      int a, l;
      bit w;
      a = $urandom % MSZ;
      l = 1 + ($urandom % 24);
      w = $urandom % 2;
      burst(a, l, w, w && ($urandom % 2), 0);
      if (w) burst(a, l, 0, 0, 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule